// File: doc/BRIEF.md
# Sequential Integer Divider with Zero-Divisor Trap

This block divides one operand by another, as signed two's-complement or as unsigned numbers, producing one quotient bit per clock with a restoring shift-and-subtract loop. A one-cycle start pulse presents the dividend, the divisor and a mode select. A one-cycle done strobe marks a new quotient, which then stays on the output until the next result. Signed operands are first turned into magnitudes. The unsigned quotient of the magnitudes is negated when the operand signs differ, so the signed quotient truncates toward zero.

A zero divisor skips the iteration. It gives a zero quotient on the cycle after start. Every accepted divide rewrites a sticky divide-by-zero status bit, so the bit always describes the latest divide. A zero divisor also asks the surrounding core for a hardware exception, but only when the global exception enable is set and the per-core suppression bit is clear. In that case the cause output is loaded with the divide-by-zero cause code. The exception vectoring logic and the register file sit outside this block.

Top module: `zdiv_unit`

## Requirements
- R1: With mode select low (unsigned), a nonzero divisor gives quotient floor(dividend / divisor), with both operands read as unsigned W-bit numbers.
- R2: With mode select high (signed), a nonzero divisor gives the two's-complement quotient truncated toward zero. The most negative value divided by -1 gives the most negative value, and no exception request follows.
- R3: A zero divisor, in either mode, gives quotient 0 with done high on the cycle after the start edge, and busy never rises.
- R4: For a nonzero divisor, busy is high from the cycle after the start edge until the result. Done rises exactly W clock edges after the start edge. Busy and done are never high together.
- R5: The divide-by-zero status reads 1 from the cycle after a start with a zero divisor, and 0 from the cycle after a start with a nonzero divisor. It holds between starts.
- R6: A zero divisor with the exception enable high and the suppression bit low gives a one-cycle exception request together with done, and the cause output is loaded with DZ_CODE (default 5).
- R7: A zero divisor with the exception enable low, or with the suppression bit high, gives no exception request and leaves the cause output unchanged.
- R8: A start pulse while busy is high is ignored. The running divide completes with its own quotient, latency and status.
- R9: Out of reset, busy, done, quotient, status, exception request and cause are all 0.
- R10: The quotient output changes only on a cycle with done high, and holds between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| dividend_i | input | W | Dividend operand |
| divisor_i | input | W | Divisor operand |
| signed_i | input | 1 | 1 = signed division, 0 = unsigned |
| exc_en_i | input | 1 | Global exception enable |
| dz_supp_i | input | 1 | Suppress divide-by-zero exceptions when high |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle result strobe |
| quot_o | output | W | Quotient, held between results |
| dz_flag_o | output | 1 | Sticky divide-by-zero status |
| exc_req_o | output | 1 | One-cycle exception request |
| exc_cause_o | output | CAUSE_W | Exception cause code |

## Verification
The bench builds the divider at 6 bits and runs every dividend and divisor pair in both modes. The expected quotient comes from integer arithmetic. This tells sign-correction faults apart from iteration faults, and exercises the most-negative over minus-one and zero-divisor cases on the way. Every divide also checks latency, status and exception request. Directed runs then sweep the four enable and suppression combinations, start pulses issued during a running divide, and the holding of the quotient after done.

// File: rtl/zdiv_pkg.sv
package zdiv_pkg;
  typedef enum logic {
    MODE_UNS = 1'b0,
    MODE_SGN = 1'b1
  } zdiv_mode_e;

  localparam int DEF_CAUSE_W = 5;
  localparam int DEF_DZ_CODE = 5;
endpackage

// File: rtl/zdiv_sign_prep.sv
module zdiv_sign_prep
  import zdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  input  zdiv_mode_e   mode_i,
  output logic [W-1:0] dvd_mag_o,
  output logic [W-1:0] dvs_mag_o,
  output logic         neg_o,
  output logic         dvs_zero_o
);
  logic dvd_neg;
  logic dvs_neg;

  always_comb begin
    dvd_neg    = (mode_i == MODE_SGN) && dvd_i[W-1];
    dvs_neg    = (mode_i == MODE_SGN) && dvs_i[W-1];
    dvd_mag_o  = dvd_neg ? (~dvd_i + 1'b1) : dvd_i;
    dvs_mag_o  = dvs_neg ? (~dvs_i + 1'b1) : dvs_i;
    neg_o      = dvd_neg ^ dvs_neg;
    dvs_zero_o = (dvs_i == '0);
  end
endmodule

// File: rtl/zdiv_core.sv
module zdiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         zero_i,
  input  logic         neg_i,
  input  logic [W-1:0] dvd_mag_i,
  input  logic [W-1:0] dvs_mag_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          neg_q, neg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [W-1:0]  quot_q, quot_d;

  logic [W:0]    trial;
  logic          fits;
  logic [W-1:0]  rem_step;
  logic [W-1:0]  acc_step;
  logic          last;

  always_comb begin
    trial    = {rem_q, acc_q[W-1]} - {1'b0, dvs_q};
    fits     = ~trial[W];
    rem_step = fits ? trial[W-1:0] : {rem_q[W-2:0], acc_q[W-1]};
    acc_step = {acc_q[W-2:0], fits};
    last     = (cnt_q == CW'(1));
  end

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    neg_d  = neg_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    acc_d  = acc_q;
    dvs_d  = dvs_q;
    quot_d = quot_q;
    if (load_i) begin
      if (zero_i) begin
        done_d = 1'b1;
        quot_d = '0;
      end else begin
        busy_d = 1'b1;
        cnt_d  = CW'(W);
        rem_d  = '0;
        acc_d  = dvd_mag_i;
        dvs_d  = dvs_mag_i;
        neg_d  = neg_i;
      end
    end else if (busy_q) begin
      rem_d = rem_step;
      acc_d = acc_step;
      cnt_d = cnt_q - CW'(1);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        quot_d = neg_q ? (~acc_step + 1'b1) : acc_step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
      dvs_q  <= '0;
      quot_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      neg_q  <= neg_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      acc_q  <= acc_d;
      dvs_q  <= dvs_d;
      quot_q <= quot_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quot_q;
endmodule

// File: rtl/zdiv_trap.sv
module zdiv_trap #(
  parameter int CAUSE_W = 5,
  parameter int DZ_CODE = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic               zero_i,
  input  logic               exc_en_i,
  input  logic               supp_i,
  output logic               dz_flag_o,
  output logic               exc_req_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               flag_q, flag_d;
  logic               req_q, req_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               raise;

  always_comb begin
    raise   = accept_i && zero_i && exc_en_i && !supp_i;
    flag_d  = flag_q;
    req_d   = raise;
    cause_d = cause_q;
    if (accept_i) flag_d = zero_i;
    if (raise) cause_d = CAUSE_W'(DZ_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      req_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      flag_q  <= flag_d;
      req_q   <= req_d;
      cause_q <= cause_d;
    end
  end

  assign dz_flag_o = flag_q;
  assign exc_req_o = req_q;
  assign cause_o   = cause_q;
endmodule

// File: rtl/zdiv_unit.sv
module zdiv_unit
  import zdiv_pkg::*;
#(
  parameter int W       = 32,
  parameter int CAUSE_W = DEF_CAUSE_W,
  parameter int DZ_CODE = DEF_DZ_CODE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [W-1:0]       dividend_i,
  input  logic [W-1:0]       divisor_i,
  input  logic               signed_i,
  input  logic               exc_en_i,
  input  logic               dz_supp_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [W-1:0]       quot_o,
  output logic               dz_flag_o,
  output logic               exc_req_o,
  output logic [CAUSE_W-1:0] exc_cause_o
);
  logic         accept;
  logic [W-1:0] dvd_mag;
  logic [W-1:0] dvs_mag;
  logic         neg;
  logic         dvs_zero;
  zdiv_mode_e   mode;

  assign mode   = signed_i ? MODE_SGN : MODE_UNS;
  assign accept = start_i && !busy_o;

  zdiv_sign_prep #(.W(W)) u_prep (
    .dvd_i      (dividend_i),
    .dvs_i      (divisor_i),
    .mode_i     (mode),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .neg_o      (neg),
    .dvs_zero_o (dvs_zero)
  );

  zdiv_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept),
    .zero_i    (dvs_zero),
    .neg_i     (neg),
    .dvd_mag_i (dvd_mag),
    .dvs_mag_i (dvs_mag),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .quot_o    (quot_o)
  );

  zdiv_trap #(.CAUSE_W(CAUSE_W), .DZ_CODE(DZ_CODE)) u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .zero_i    (dvs_zero),
    .exc_en_i  (exc_en_i),
    .supp_i    (dz_supp_i),
    .dz_flag_o (dz_flag_o),
    .exc_req_o (exc_req_o),
    .cause_o   (exc_cause_o)
  );
endmodule

// File: rtl/zdiv_unit_chk.sv
module zdiv_unit_chk #(
  parameter int W       = 32,
  parameter int CAUSE_W = 5,
  parameter int DZ_CODE = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [W-1:0]       divisor_i,
  input logic               exc_en_i,
  input logic               dz_supp_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [W-1:0]       quot_o,
  input logic               dz_flag_o,
  input logic               exc_req_o,
  input logic [CAUSE_W-1:0] exc_cause_o
);
  a_r3_zero_quick: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && divisor_i == '0) |=> (done_o && quot_o == '0 && !busy_o));

  a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && divisor_i != '0) |=> busy_o);

  a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && divisor_i != '0) |=> !dz_flag_o);

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && divisor_i == '0) |=> dz_flag_o);

  a_r6_req_context: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> (done_o && dz_flag_o && exc_cause_o == CAUSE_W'(DZ_CODE)));

  a_r7_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (!exc_en_i || dz_supp_i)) |=> (!exc_req_o && $stable(exc_cause_o)));

  a_r10_quot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(quot_o));
endmodule

bind zdiv_unit zdiv_unit_chk #(.W(W), .CAUSE_W(CAUSE_W), .DZ_CODE(DZ_CODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .divisor_i   (divisor_i),
  .exc_en_i    (exc_en_i),
  .dz_supp_i   (dz_supp_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .quot_o      (quot_o),
  .dz_flag_o   (dz_flag_o),
  .exc_req_o   (exc_req_o),
  .exc_cause_o (exc_cause_o)
);

// File: tb/tb_zdiv_unit.sv
module tb_zdiv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 6;
  localparam int CAUSE_W    = 5;
  localparam int DZ_CODE    = 5;
  localparam int N          = 1 << W;

  logic               clk;
  logic               rst_n;
  logic               start_i;
  logic [W-1:0]       dividend_i;
  logic [W-1:0]       divisor_i;
  logic               signed_i;
  logic               exc_en_i;
  logic               dz_supp_i;
  logic               busy_o;
  logic               done_o;
  logic [W-1:0]       quot_o;
  logic               dz_flag_o;
  logic               exc_req_o;
  logic [CAUSE_W-1:0] exc_cause_o;

  int checks;
  int errors;
  bit finished;

  zdiv_unit #(.W(W), .CAUSE_W(CAUSE_W), .DZ_CODE(DZ_CODE)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dividend_i(dividend_i),
    .divisor_i(divisor_i), .signed_i(signed_i), .exc_en_i(exc_en_i),
    .dz_supp_i(dz_supp_i), .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
    .dz_flag_o(dz_flag_o), .exc_req_o(exc_req_o), .exc_cause_o(exc_cause_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_quot(input int a, input int b, input bit sgn);
    int ia;
    int ib;
    int q;
    if (b == 0) return 0;
    if (sgn) begin
      ia = (a >= N / 2) ? a - N : a;
      ib = (b >= N / 2) ? b - N : b;
      q  = ia / ib;
    end else begin
      q = a / b;
    end
    return q & (N - 1);
  endfunction

  // Drives one divide and checks quotient, latency, status and exception.
  task automatic run_div(input int a, input int b, input bit sgn, input bit en, input bit supp);
    int cnt;
    bit raise;
    int cause_before;
    raise = (b == 0) && en && !supp;
    cause_before = int'(exc_cause_o);
    @(negedge clk);
    dividend_i = W'(a);
    divisor_i  = W'(b);
    signed_i   = sgn;
    exc_en_i   = en;
    dz_supp_i  = supp;
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R5 status after start", int'(dz_flag_o), (b == 0) ? 1 : 0);
    if (b == 0) begin
      check("R3 zero divisor done", int'(done_o), 1);
      check("R3 zero divisor busy", int'(busy_o), 0);
    end else begin
      check("R4 busy after start", int'(busy_o), 1);
      cnt = 0;
      while (!done_o && cnt < W + 4) begin
        @(negedge clk);
        cnt++;
        if (!done_o && !busy_o) cnt = W + 4;
      end
      check("R4 latency", cnt, W);
      check("R4 busy low at done", int'(busy_o), 0);
    end
    check(sgn ? "R2 signed quotient" : "R1 unsigned quotient", int'(quot_o), expect_quot(a, b, sgn));
    check(raise ? "R6 exception request" : "R7 no exception request", int'(exc_req_o), raise ? 1 : 0);
    check(raise ? "R6 cause code" : "R7 cause unchanged", int'(exc_cause_o), raise ? DZ_CODE : cause_before);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    start_i = 0; dividend_i = '0; divisor_i = '0; signed_i = 0;
    exc_en_i = 0; dz_supp_i = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 busy", int'(busy_o), 0);
    check("R9 done", int'(done_o), 0);
    check("R9 quot", int'(quot_o), 0);
    check("R9 status", int'(dz_flag_o), 0);
    check("R9 exc req", int'(exc_req_o), 0);
    check("R9 cause", int'(exc_cause_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R7: disabled or suppressed, cause stays at its reset value
    run_div(17, 0, 0, 0, 0);
    run_div(17, 0, 1, 1, 1);
    run_div(17, 0, 0, 0, 1);
    // R6
    run_div(9, 0, 1, 1, 0);
    // R2 most negative over -1
    run_div(N / 2, N - 1, 1, 1, 0);

    // R8: start pulses while busy are ignored
    @(negedge clk);
    dividend_i = W'(45); divisor_i = W'(7); signed_i = 0; exc_en_i = 1; dz_supp_i = 0;
    start_i = 1;
    @(negedge clk);
    dividend_i = W'(3); divisor_i = '0; signed_i = 1;
    repeat (3) @(negedge clk);
    start_i = 0;
    check("R8 status unchanged", int'(dz_flag_o), 0);
    check("R8 still busy", int'(busy_o), 1);
    begin
      int waited;
      waited = 3;
      while (!done_o && waited < W + 4) begin
        @(negedge clk);
        waited++;
      end
      check("R8 latency kept", waited, W);
      check("R8 quotient kept", int'(quot_o), 45 / 7);
      check("R8 no exception", int'(exc_req_o), 0);
    end
    // R10: quotient held after done
    repeat (4) @(negedge clk);
    check("R10 quotient held", int'(quot_o), 45 / 7);
    check("R10 done pulse ended", int'(done_o), 0);

    // Exhaustive sweep in both modes
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++)
          run_div(a, b, s[0], 1, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule